// File: doc/BRIEF.md
# Raster position interrupt generator

This block sits beside a raster timing generator and turns its counters into interrupt pulses. It observes the raster line counter, the clock-within-line counter, the field parity flag, the frame's total line count and the current line length. It raises three single-cycle pulses: two from vertical position compares and one from a horizontal position compare.

Software programs the targets through a small write port with two registers. The vertical register holds two independent compare lines. The horizontal register holds a line field, a mode and an in-line position. All targets are given in field lines. A field line L maps to raster line 2L in the even field and to 2L+1 in the odd field.

The horizontal interrupt has three behaviours. It can fire once per frame at a fixed line. It can repeat every N field lines, with the target wrapping within half a frame. It can also fire on every field line. Both registers can be read back through the same port.

Top module: `raster_irq_gen`

## Requirements
- R1: The vertical register (wr_sel/rd_sel = 0) takes compare line A from bits 25:16 and compare line B from bits 9:0; read back, it shows the written value ANDed with 0x03FF03FF.
- R2: The horizontal register (wr_sel/rd_sel = 1) takes a line field from bits 9:0, a mode from bits 13:12 and an in-line position P from bits 25:16; read back, it shows the written value ANDed with 0x03FF33FF.
- R3: A vertical compare programmed with field line L pulses when line_cnt equals 2L+field_odd and clk_pos is 0 (vpos_irq[0] for line A, vpos_irq[1] for line B).
- R4: If a mapped raster line (2L+field_odd) is not below total_lines, the matching interrupt never pulses for that line.
- R5: The horizontal interrupt fires at clk_pos = 2P, clamped to line_len when 2P exceeds line_len.
- R6: Mode 0 fires once per frame at the programmed field line. Mode 3 behaves exactly like mode 0.
- R7: Mode 1 repeats every N field lines, where N is the line field. On the write, the first target is line_cnt/2 + N. After each firing, the target advances by N. The target is then reduced by total_lines/2 until it is no greater than total_lines/2.
- R8: Mode 2 behaves as mode 1 with N = 1, whatever the line field holds.
- R9: Each output is a one-cycle pulse raised on entry into its match condition. A position held for several cycles gives one pulse.
- R10: A pulse appears in the cycle after the clock edge that samples the matching counters. A register write is used for matching from the next clock edge onward.
- R11: After reset, all outputs are low and both registers read zero. Targets are then field line 0 with position 0 in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 vertical, 1 horizontal |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 vertical, 1 horizontal |
| rd_data | output | 32 | Masked register contents |
| line_cnt | input | LINE_W | Current raster line |
| clk_pos | input | CLK_W | Clock count within the line |
| field_odd | input | 1 | 1 in the odd field |
| total_lines | input | LINE_W | Raster lines per frame |
| line_len | input | CLK_W | Line length in clocks |
| vpos_irq | output | 2 | Vertical compare pulses (A, B) |
| hpos_irq | output | 1 | Horizontal position pulse |

## Verification
The bench keeps the default widths of 11-bit line and clock counters, so every 10-bit field line and a doubled in-line position up to 2046 can be represented. At run time it drives a short frame of 20 raster lines and a 40-clock line. With these values the disable boundary at line 10 (raster 20) and the half-frame wrap at 10 field lines are reached in a few steps. The 40-clock line also makes the position clamp visible with modest register values.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

    localparam int FLD_W = 10;
    localparam int REG_W = 32;
    localparam int NUM_V = 2;

    localparam logic [REG_W-1:0] VREG_MASK = 32'h03FF_03FF;
    localparam logic [REG_W-1:0] HREG_MASK = 32'h03FF_33FF;

    typedef enum logic [1:0] {
        HM_FRAME      = 2'd0,
        HM_EVERY_N    = 2'd1,
        HM_EVERY_LINE = 2'd2,
        HM_RSVD       = 2'd3
    } hmode_e;

    typedef struct packed {
        logic [FLD_W-1:0] line_a;
        logic [FLD_W-1:0] line_b;
    } vcfg_t;

    typedef struct packed {
        logic [FLD_W-1:0] line;
        hmode_e           mode;
        logic [FLD_W-1:0] hpos;
    } hcfg_t;

    function automatic vcfg_t vcfg_of(input logic [REG_W-1:0] w);
        vcfg_t r;
        r.line_a = w[25:16];
        r.line_b = w[9:0];
        return r;
    endfunction

    function automatic hcfg_t hcfg_of(input logic [REG_W-1:0] w);
        hcfg_t r;
        r.line = w[9:0];
        r.mode = hmode_e'(w[13:12]);
        r.hpos = w[25:16];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] vcfg_word(input vcfg_t c);
        logic [REG_W-1:0] r;
        r        = '0;
        r[25:16] = c.line_a;
        r[9:0]   = c.line_b;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] hcfg_word(input hcfg_t c);
        logic [REG_W-1:0] r;
        r        = '0;
        r[25:16] = c.hpos;
        r[13:12] = c.mode;
        r[9:0]   = c.line;
        return r;
    endfunction

    // Field line to raster line: 2L + parity
    function automatic logic [FLD_W:0] map_line(input logic [FLD_W-1:0] l,
                                                input logic odd);
        return {l, odd};
    endfunction

    function automatic logic is_repeat(input hmode_e m);
        return (m == HM_EVERY_N) || (m == HM_EVERY_LINE);
    endfunction

    function automatic logic [FLD_W-1:0] step_of(input hcfg_t c);
        return (c.mode == HM_EVERY_LINE) ? FLD_W'(1) : c.line;
    endfunction

endpackage

// File: rtl/rirq_regs.sv
module rirq_regs
    import rirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output vcfg_t            vcfg_q,
    output hcfg_t            hcfg_q,
    output hcfg_t            hcfg_new,
    output logic             h_load
);

    assign hcfg_new = hcfg_of(wr_data);
    assign h_load   = wr_en & wr_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcfg_q <= '0;
            hcfg_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) hcfg_q <= hcfg_new;
            else        vcfg_q <= vcfg_of(wr_data);
        end
    end

    assign rd_data = rd_sel ? hcfg_word(hcfg_q) : vcfg_word(vcfg_q);

endmodule

// File: rtl/rirq_vcmp.sv
module rirq_vcmp
    import rirq_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CLK_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLD_W-1:0]  fld,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [CLK_W-1:0]  clk_pos,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] total_lines,
    output logic              irq
);

    localparam int BASE_W = (LINE_W > FLD_W + 1) ? LINE_W : FLD_W + 1;
    localparam int CMP_W  = BASE_W + 1;

    logic [CMP_W-1:0] tgt_x, cnt_x, tot_x;
    logic             hit, hit_d, rise;

    assign tgt_x = CMP_W'(map_line(fld, field_odd));
    assign cnt_x = CMP_W'(line_cnt);
    assign tot_x = CMP_W'(total_lines);

    assign hit  = (tgt_x < tot_x) && (cnt_x == tgt_x) && (clk_pos == '0);
    assign rise = hit & ~hit_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_d <= 1'b0;
            irq   <= 1'b0;
        end else begin
            hit_d <= hit;
            irq   <= rise;
        end
    end

endmodule

// File: rtl/rirq_hsched.sv
module rirq_hsched
    import rirq_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CLK_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  hcfg_t             cfg_new,
    input  hcfg_t             cfg,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [CLK_W-1:0]  clk_pos,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] total_lines,
    input  logic [CLK_W-1:0]  line_len,
    output logic              irq
);

    localparam int BASE_W = (LINE_W > FLD_W + 1) ? LINE_W : FLD_W + 1;
    localparam int TGT_W  = BASE_W + 1;
    localparam int CMP_W  = TGT_W + 1;

    logic [TGT_W-1:0] tgt_q, half, step_cur, step_nxt, base_nxt;
    logic [CMP_W-1:0] map_x;
    logic [CLK_W-1:0] hp2, fire_pos;
    logic             hit, hit_d, rise, rep_cur;

    assign half     = TGT_W'(total_lines >> 1);
    assign step_cur = TGT_W'(step_of(cfg));
    assign step_nxt = TGT_W'(step_of(cfg_new));
    assign base_nxt = TGT_W'(line_cnt >> 1);
    assign rep_cur  = is_repeat(cfg.mode);

    assign hp2      = CLK_W'({cfg.hpos, 1'b0});
    assign fire_pos = (hp2 > line_len) ? line_len : hp2;

    assign map_x = {tgt_q, field_odd};
    assign hit   = (map_x < CMP_W'(total_lines)) &&
                   (map_x == CMP_W'(line_cnt)) &&
                   (clk_pos == fire_pos);
    assign rise  = hit & ~hit_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            hit_d <= 1'b0;
            irq   <= 1'b0;
        end else begin
            hit_d <= hit;
            irq   <= rise;
            if (load) begin
                tgt_q <= is_repeat(cfg_new.mode) ? base_nxt + step_nxt
                                                 : TGT_W'(cfg_new.line);
            end else if (rise && rep_cur) begin
                tgt_q <= tgt_q + step_cur;
            end else if (rep_cur && (half != '0) && (tgt_q > half)) begin
                tgt_q <= tgt_q - half;
            end
        end
    end

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
    import rirq_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CLK_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              rd_sel,
    output logic [31:0]       rd_data,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [CLK_W-1:0]  clk_pos,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] total_lines,
    input  logic [CLK_W-1:0]  line_len,
    output logic [1:0]        vpos_irq,
    output logic              hpos_irq
);

    vcfg_t            vcfg_q;
    hcfg_t            hcfg_q, hcfg_new;
    logic             h_load;
    logic [FLD_W-1:0] vfld [NUM_V];

    rirq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .vcfg_q   (vcfg_q),
        .hcfg_q   (hcfg_q),
        .hcfg_new (hcfg_new),
        .h_load   (h_load)
    );

    assign vfld[0] = vcfg_q.line_a;
    assign vfld[1] = vcfg_q.line_b;

    for (genvar k = 0; k < NUM_V; k++) begin : g_vcmp
        rirq_vcmp #(.LINE_W(LINE_W), .CLK_W(CLK_W)) u_vcmp (
            .clk         (clk),
            .rst         (rst),
            .fld         (vfld[k]),
            .line_cnt    (line_cnt),
            .clk_pos     (clk_pos),
            .field_odd   (field_odd),
            .total_lines (total_lines),
            .irq         (vpos_irq[k])
        );
    end

    rirq_hsched #(.LINE_W(LINE_W), .CLK_W(CLK_W)) u_hsched (
        .clk         (clk),
        .rst         (rst),
        .load        (h_load),
        .cfg_new     (hcfg_new),
        .cfg         (hcfg_q),
        .line_cnt    (line_cnt),
        .clk_pos     (clk_pos),
        .field_odd   (field_odd),
        .total_lines (total_lines),
        .line_len    (line_len),
        .irq         (hpos_irq)
    );

endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk
    import rirq_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CLK_W  = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_sel,
    input logic [31:0]       rd_data,
    input logic [LINE_W-1:0] line_cnt,
    input logic [LINE_W-1:0] total_lines,
    input logic [CLK_W-1:0]  clk_pos,
    input logic [CLK_W-1:0]  line_len,
    input logic              field_odd,
    input logic [1:0]        vpos_irq,
    input logic              hpos_irq,
    input vcfg_t             vcfg_q,
    input hcfg_t             hcfg_q
);

    logic [FLD_W:0]   vmap0, vmap1;
    logic [CLK_W-1:0] exp_pos, dbl;

    assign vmap0   = map_line(vcfg_q.line_a, field_odd);
    assign vmap1   = map_line(vcfg_q.line_b, field_odd);
    assign dbl     = CLK_W'(hcfg_q.hpos) << 1;
    assign exp_pos = (dbl > line_len) ? line_len : dbl;

    // R9: pulses last one cycle
    a_r9_va_single: assert property (@(posedge clk) disable iff (rst)
        vpos_irq[0] |=> !vpos_irq[0]);
    a_r9_vb_single: assert property (@(posedge clk) disable iff (rst)
        vpos_irq[1] |=> !vpos_irq[1]);
    a_r9_h_single: assert property (@(posedge clk) disable iff (rst)
        hpos_irq |=> !hpos_irq);

    // R3: vertical pulse follows the mapped line at position 0
    a_r3_va_place: assert property (@(posedge clk) disable iff (rst)
        vpos_irq[0] |-> ($past(clk_pos) == '0 &&
                         32'($past(line_cnt)) == 32'($past(vmap0))));
    a_r3_vb_place: assert property (@(posedge clk) disable iff (rst)
        vpos_irq[1] |-> ($past(clk_pos) == '0 &&
                         32'($past(line_cnt)) == 32'($past(vmap1))));

    // R4: no pulse on a line outside the frame
    a_r4_va_range: assert property (@(posedge clk) disable iff (rst)
        vpos_irq[0] |-> 32'($past(vmap0)) < 32'($past(total_lines)));
    a_r4_vb_range: assert property (@(posedge clk) disable iff (rst)
        vpos_irq[1] |-> 32'($past(vmap1)) < 32'($past(total_lines)));
    a_r4_h_range: assert property (@(posedge clk) disable iff (rst)
        hpos_irq |-> 32'($past(line_cnt)) < 32'($past(total_lines)));

    // R5: horizontal pulse at the clamped in-line position
    a_r5_h_pos: assert property (@(posedge clk) disable iff (rst)
        hpos_irq |-> $past(clk_pos) == $past(exp_pos));

    // R1, R2: read-back masks
    a_r1_vread_mask: assert property (@(posedge clk) disable iff (rst)
        !rd_sel |-> (rd_data & ~VREG_MASK) == '0);
    a_r2_hread_mask: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> (rd_data & ~HREG_MASK) == '0);

endmodule

bind raster_irq_gen raster_irq_chk #(.LINE_W(LINE_W), .CLK_W(CLK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .line_cnt    (line_cnt),
    .total_lines (total_lines),
    .clk_pos     (clk_pos),
    .line_len    (line_len),
    .field_odd   (field_odd),
    .vpos_irq    (vpos_irq),
    .hpos_irq    (hpos_irq),
    .vcfg_q      (vcfg_q),
    .hcfg_q      (hcfg_q)
);

// File: tb/sim_raster_irq_gen.sv
`timescale 1ns/1ps
module sim_raster_irq_gen;

    localparam int LINE_W = 11;
    localparam int CLK_W  = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic [LINE_W-1:0] line_cnt = LINE_W'(31);
    logic [CLK_W-1:0]  clk_pos = CLK_W'(1);
    logic              field_odd = 1'b0;
    logic [LINE_W-1:0] total_lines = LINE_W'(20);
    logic [CLK_W-1:0]  line_len = CLK_W'(40);
    logic [1:0]        vpos_irq;
    logic              hpos_irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    typedef struct {
        logic [2:0] e;
        string      r;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    raster_irq_gen #(.LINE_W(LINE_W), .CLK_W(CLK_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .line_cnt(line_cnt), .clk_pos(clk_pos), .field_odd(field_odd),
        .total_lines(total_lines), .line_len(line_len),
        .vpos_irq(vpos_irq), .hpos_irq(hpos_irq)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Driver: one cycle of stimulus plus the pulses expected after the next edge
    task automatic drive(input logic w, input logic s, input logic [31:0] d,
                         input int ln, input int cp, input logic odd,
                         input logic [2:0] e, input string r);
        item_t it;
        @(negedge clk);
        wr_en     = w;
        wr_sel    = s;
        wr_data   = d;
        line_cnt  = LINE_W'(ln);
        clk_pos   = CLK_W'(cp);
        field_odd = odd;
        it.e = e;
        it.r = r;
        q.push_back(it);
    endtask

    task automatic step(input int ln, input int cp, input logic odd,
                        input logic [2:0] e, input string r);
        drive(1'b0, 1'b0, 32'h0, ln, cp, odd, e, r);
    endtask

    task automatic park(input string r);
        step(31, 1, 1'b0, 3'b000, r);
    endtask

    task automatic wr(input logic s, input logic [31:0] d, input string r);
        drive(1'b1, s, d, 31, 1, 1'b0, 3'b000, r);
    endtask

    task automatic check_rd(input logic s, input logic [31:0] exp, input string r);
        park(r);
        rd_sel = s;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data got %h expected %h", r, rd_data, exp);
        end
    endtask

    // Monitor: compare pulses after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if ({hpos_irq, vpos_irq} !== it.e) begin
                    n_bad++;
                    $display("FAIL %s: {h,vb,va} got %b expected %b",
                             it.r, {hpos_irq, vpos_irq}, it.e);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run got no end, expected an end");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        n_chk++;
        if ({hpos_irq, vpos_irq} !== 3'b000) begin
            n_bad++;
            $display("FAIL R11: outputs got %b expected 000", {hpos_irq, vpos_irq});
        end
        check_rd(1'b0, 32'h0, "R11 vreg zero");
        check_rd(1'b1, 32'h0, "R11 hreg zero");
        step(0, 0, 1'b0, 3'b111, "R11 zero targets fire at line 0");
        park("R11");

        // R1 / R3 / R9
        wr(1'b0, 32'hFC03_FC04, "R1 write");
        check_rd(1'b0, 32'h0003_0004, "R1 vreg mask");
        step(6, 0, 1'b0, 3'b001, "R3 line A even");
        step(6, 0, 1'b0, 3'b000, "R9 held position");
        step(7, 0, 1'b0, 3'b000, "R3 wrong parity");
        step(7, 0, 1'b1, 3'b001, "R3 line A odd");
        park("R3");
        step(8, 0, 1'b0, 3'b010, "R3 line B even");
        park("R3");
        step(9, 0, 1'b1, 3'b010, "R3 line B odd");
        park("R3");
        step(8, 1, 1'b0, 3'b000, "R3 nonzero position");
        park("R3");

        // R4: line A = 10 -> raster 20/21 out of frame; line B = 9 -> 18/19
        wr(1'b0, 32'h000A_0009, "R4 write");
        step(20, 0, 1'b0, 3'b000, "R4 raster 20 disabled");
        park("R4");
        step(21, 0, 1'b1, 3'b000, "R4 raster 21 disabled");
        park("R4");
        step(18, 0, 1'b0, 3'b010, "R4 raster 18 fires");
        park("R4");
        step(19, 0, 1'b1, 3'b010, "R4 raster 19 fires");
        park("R4");

        // R10: write used from next edge
        wr(1'b0, 32'h03FF_03FF, "R10 disable");
        drive(1'b1, 1'b0, 32'h0002_0000, 4, 0, 1'b0, 3'b000, "R10 write cycle");
        step(4, 0, 1'b0, 3'b001, "R10 next cycle");
        park("R10");
        wr(1'b0, 32'h03FF_03FF, "R10 disable");

        // R6 / R5: mode 0, line 5, P = 7 -> clk 14
        wr(1'b1, 32'h0007_0005, "R6 write");
        step(10, 14, 1'b0, 3'b100, "R6 mode 0 even");
        park("R6");
        step(10, 13, 1'b0, 3'b000, "R5 off position");
        step(11, 14, 1'b1, 3'b100, "R6 mode 0 odd");
        park("R6");
        step(12, 14, 1'b0, 3'b000, "R6 other line");
        wr(1'b1, 32'h0007_3005, "R6 mode 3 write");
        check_rd(1'b1, 32'h0007_3005, "R2 mode 3 read");
        step(10, 14, 1'b0, 3'b100, "R6 mode 3 as mode 0");
        park("R6");

        // R5 clamp: P = 30 -> 60 > 40
        wr(1'b1, 32'h001E_0005, "R5 write");
        step(10, 40, 1'b0, 3'b100, "R5 clamp to line length");
        park("R5");
        step(10, 60, 1'b0, 3'b000, "R5 unclamped position");
        park("R5");

        // R2 / R1 masks
        wr(1'b1, 32'hFFFF_FFFF, "R2 write");
        check_rd(1'b1, 32'h03FF_33FF, "R2 hreg mask");
        wr(1'b0, 32'hFFFF_FFFF, "R1 write");
        check_rd(1'b0, 32'h03FF_03FF, "R1 vreg mask all ones");

        // R7: mode 1, N = 3, written at raster 4 -> first target 5
        drive(1'b1, 1'b1, 32'h0000_1003, 4, 1, 1'b0, 3'b000, "R7 write");
        step(10, 0, 1'b0, 3'b100, "R7 first target");
        park("R7");
        step(16, 0, 1'b0, 3'b100, "R7 advance by N");
        park("R7");
        park("R7");
        step(2, 0, 1'b0, 3'b100, "R7 wrap by half frame");
        park("R7");
        step(8, 0, 1'b0, 3'b100, "R7 after wrap");
        park("R7");
        step(10, 0, 1'b0, 3'b000, "R7 old target idle");
        park("R7");
        drive(1'b1, 1'b1, 32'h0000_1009, 8, 1, 1'b0, 3'b000, "R7 write N=9");
        park("R7");
        step(6, 0, 1'b0, 3'b100, "R7 first target wrapped");
        park("R7");

        // R8: mode 2, line field 7 ignored, P = 2 -> clk 4, written at raster 6
        drive(1'b1, 1'b1, 32'h0002_2007, 6, 1, 1'b0, 3'b000, "R8 write");
        step(8, 4, 1'b0, 3'b100, "R8 next field line");
        park("R8");
        step(10, 4, 1'b0, 3'b100, "R8 every line");
        park("R8");
        step(13, 4, 1'b1, 3'b100, "R8 odd field");
        park("R8");
        step(16, 4, 1'b0, 3'b000, "R8 skipped line");
        park("R8");

        repeat (3) @(posedge clk);
        #6;
        done = 1;
        summary();
        $finish;
    end

endmodule